// File: doc/BRIEF.md
# Inter-master doorbell unit

This block lets up to 32 bus masters notify each other. Every receiving master owns one doorbell, and each doorbell sits in a 16-byte register window. A master rings a doorbell by writing a 1 to that doorbell's trigger register. The bus supplies the writer's master ID next to the write, so the hardware records the sender as one bit per master ID.

The receiver sets an enable mask that selects which senders may raise its pending bits. A second register records every ring by sender, whether or not the sender is enabled. A doorbell's interrupt output stays high while any of its pending bits is set. Software clears the pending bits by writing back the value it read. A 1 clears a bit and a 0 leaves it alone, so a ring that arrives between the read and the write-back survives.

The register port is a single write strobe with a byte address, write data and the ID of the requesting master. Read data follows the address combinationally. The address is split into a doorbell index (bits above bit 3) and a register select (bits 3:2).

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every enable, raw and pending bit of every doorbell is zero and every irq output is low.
- R2: A write to offset 0x4 of a doorbell window loads the whole data word into that doorbell's enable mask, and a read of offset 0x4 returns it.
- R3: A write to offset 0x0 with wdata bit 0 set, from master m, sets bit m of that doorbell's raw register (read at offset 0x8) whatever the enable mask holds. It also sets bit m of the pending register (read at offset 0xC), but only if enable bit m is 1.
- R4: A write to offset 0x0 with wdata bit 0 clear changes nothing, and a read of offset 0x0 always returns zero.
- R5: A write to offset 0xC clears each pending bit whose wdata bit is 1 and leaves each bit whose wdata bit is 0 unchanged. A ring that arrives after the read and before this write-back is kept.
- R6: A write to offset 0x8 clears each raw bit whose wdata bit is 1 and leaves the others unchanged.
- R7: irq[d] is high exactly when doorbell d has at least one pending bit set, one cycle after the write that changed it.
- R8: Clearing an enable bit does not clear a pending bit that is already set.
- R9: An address whose doorbell index is N_DB or above ignores writes and reads as zero.
- R10: A ring, enable write or clear on one doorbell leaves every other doorbell's registers and irq unchanged. If a ring sets a bit in the same cycle that a clear hits it, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (7) | Byte address: doorbell index above bit 3, register select in bits 3:2 |
| wdata | input | N_MASTERS (32) | Write data |
| src_id | input | IDW (5) | ID of the master making the access |
| rdata | output | N_MASTERS (32) | Read data for addr, combinational |
| irq | output | N_DB (6) | One interrupt per doorbell |

## Verification
The hardest case to reach is the race behind the write-back clear. A sender rings after software has read the pending register but before it writes the read value back. The bench builds this directly: it rings from one master, then rings from a second master, then writes back a mask that holds only the first sender's bit. It then checks that the second sender's pending bit is still set and that the interrupt stays high. Rings from a disabled sender and from the highest master ID, 31, show that the raw and pending registers keep track of senders separately.

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int N_MASTERS = 32,
  parameter int N_DB      = 6,
  localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int DBW = (N_DB > 1) ? $clog2(N_DB) : 1,
  localparam int AW  = DBW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [N_MASTERS-1:0] wdata,
  input  logic [IDW-1:0]       src_id,
  output logic [N_MASTERS-1:0] rdata,
  output logic [N_DB-1:0]      irq
);

  logic [DBW-1:0]       idx;
  logic [1:0]           sel;
  logic [N_MASTERS-1:0] sender;
  logic [N_MASTERS-1:0] en_q   [N_DB];
  logic [N_MASTERS-1:0] raw_q  [N_DB];
  logic [N_MASTERS-1:0] pend_q [N_DB];

  assign idx    = addr[AW-1:4];
  assign sel    = addr[3:2];
  assign sender = {{(N_MASTERS-1){1'b0}}, 1'b1} << src_id;

  for (genvar d = 0; d < N_DB; d++) begin : g_db
    logic                 wsel, ring;
    logic [N_MASTERS-1:0] set_v, clr_raw, clr_pend;

    assign wsel     = wr_en && (idx == DBW'(d));
    assign ring     = wsel && (sel == 2'd0) && wdata[0];
    assign set_v    = ring ? sender : '0;
    assign clr_raw  = (wsel && sel == 2'd2) ? wdata : '0;
    assign clr_pend = (wsel && sel == 2'd3) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[d]   <= '0;
        raw_q[d]  <= '0;
        pend_q[d] <= '0;
      end else begin
        if (wsel && sel == 2'd1) en_q[d] <= wdata;
        raw_q[d]  <= (raw_q[d] & ~clr_raw) | set_v;
        pend_q[d] <= (pend_q[d] & ~clr_pend) | (set_v & en_q[d]);
      end
    end

    assign irq[d] = |pend_q[d];

    assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[d]) |-> $past(wr_en && addr[AW-1:4] == DBW'(d) && addr[3:2] == 2'd0 && wdata[0]));

    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[d]) |-> ($past(!rst_n) ||
        $past(wr_en && addr[AW-1:4] == DBW'(d) && addr[3:2] == 2'd3)));
  end

  always_comb begin
    rdata = '0;
    for (int d = 0; d < N_DB; d++) begin
      if (idx == DBW'(d)) begin
        case (sel)
          2'd1:    rdata = en_q[d];
          2'd2:    rdata = raw_q[d];
          2'd3:    rdata = pend_q[d];
          default: rdata = '0;
        endcase
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (irq == '0));

  assert_trigger_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[3:2] == 2'd0) |-> (rdata == '0));

  assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr[AW-1:4]) >= N_DB) |=> $stable(irq));

  assert_oob_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr[AW-1:4]) >= N_DB) |-> (rdata == '0));

endmodule

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb;
  localparam int NV = 27;

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic [4:0]  src;
    logic [31:0] exp;
  } vec_t;

  // R2 enable, R3 ring/raw/pending, R4 trigger, R5 write-back race, R6 raw clear, R9, R10
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h14, 32'h0000_0006, 5'd0,  32'h0},          // enable masters 1,2 on db1
    '{1'b0, 7'h14, 32'h0,         5'd0,  32'h0000_0006},  // R2
    '{1'b1, 7'h10, 32'h1,         5'd2,  32'h0},          // ring from 2
    '{1'b0, 7'h1C, 32'h0,         5'd0,  32'h0000_0004},  // R3 pending
    '{1'b0, 7'h18, 32'h0,         5'd0,  32'h0000_0004},  // R3 raw
    '{1'b1, 7'h10, 32'h1,         5'd5,  32'h0},          // ring from disabled 5
    '{1'b0, 7'h1C, 32'h0,         5'd0,  32'h0000_0004},  // R3 disabled not pending
    '{1'b0, 7'h18, 32'h0,         5'd0,  32'h0000_0024},  // R3 raw ignores enable
    '{1'b1, 7'h10, 32'hFFFF_FFFE, 5'd1,  32'h0},          // R4 bit0 clear
    '{1'b0, 7'h1C, 32'h0,         5'd0,  32'h0000_0004},  // R4
    '{1'b0, 7'h10, 32'h0,         5'd0,  32'h0},          // R4 trigger reads 0
    '{1'b1, 7'h10, 32'h1,         5'd1,  32'h0},          // ring from 1 after "read"
    '{1'b1, 7'h1C, 32'h0000_0004, 5'd0,  32'h0},          // write back earlier read
    '{1'b0, 7'h1C, 32'h0,         5'd0,  32'h0000_0002},  // R5 late ring kept
    '{1'b1, 7'h18, 32'h0000_0020, 5'd0,  32'h0},          // clear raw bit 5
    '{1'b0, 7'h18, 32'h0,         5'd0,  32'h0000_0006},  // R6
    '{1'b0, 7'h0C, 32'h0,         5'd0,  32'h0},          // R10 db0 pending
    '{1'b0, 7'h08, 32'h0,         5'd0,  32'h0},          // R10 db0 raw
    '{1'b1, 7'h54, 32'h8000_0000, 5'd0,  32'h0},          // db5 enable master 31
    '{1'b1, 7'h50, 32'h1,         5'd31, 32'h0},          // ring from 31
    '{1'b0, 7'h5C, 32'h0,         5'd0,  32'h8000_0000},  // R3 top master
    '{1'b1, 7'h70, 32'h1,         5'd1,  32'h0},          // R9 oob ring
    '{1'b0, 7'h7C, 32'h0,         5'd0,  32'h0},          // R9
    '{1'b1, 7'h64, 32'hFFFF_FFFF, 5'd0,  32'h0},          // R9 oob enable
    '{1'b0, 7'h64, 32'h0,         5'd0,  32'h0},          // R9
    '{1'b0, 7'h1C, 32'h0,         5'd0,  32'h0000_0002},  // R10 db1 untouched
    '{1'b0, 7'h14, 32'h0,         5'd0,  32'h0000_0006}   // R10 db1 enable untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  src_id = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  doorbell_unit u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .src_id(src_id), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [4:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; src_id = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1 irq", 32'(irq), 32'h0);
    rd("R1 raw db1", 7'h18, 32'h0);
    rd("R1 enable db3", 7'h34, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].wr; addr = VEC[i].addr; wdata = VEC[i].wdata; src_id = VEC[i].src;
      #1;
      if (!VEC[i].wr) chk($sformatf("vector %0d", i), rdata, VEC[i].exp);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R7 irq follows pending: db1 and db5 pending
    #1 chk("R7 irq set", 32'(irq), 32'h22);
    // R8 disable sender 31 on db5, pending kept
    wr(7'h54, 32'h0, 5'd0);
    rd("R8 pending kept", 7'h5C, 32'h8000_0000);
    chk("R8 irq kept", 32'(irq), 32'h22);
    // R5 zero write leaves pending alone
    wr(7'h1C, 32'h0, 5'd0);
    rd("R5 zero write", 7'h1C, 32'h2);
    // R7 irq drops the cycle after clearing the last bit
    @(negedge clk);
    wr_en = 1'b1; addr = 7'h1C; wdata = 32'h2;
    #1 chk("R7 irq before edge", 32'(irq), 32'h22);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7 irq cleared", 32'(irq), 32'h20);
    // R10 db0 ring with enable, others untouched
    wr(7'h04, 32'h0000_0008, 5'd0);
    wr(7'h00, 32'h1, 5'd3);
    #1 chk("R10 only db0 rises", 32'(irq), 32'h21);
    // R1 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 irq after reset", 32'(irq), 32'h0);
    rd("R1 enable after reset", 7'h04, 32'h0);
    rd("R1 raw after reset", 7'h58, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule